// File: doc/BRIEF.md
# Shuffle-Optional Exchange Multistage Network

The block routes one word per processing-element lane through a stack of `LOG_N` switching stages, where the lane count is `N = 2**LOG_N`. Each stage can leave its lanes alone, exchange words inside chosen lane pairs, apply a perfect shuffle to all lanes, or shuffle and then exchange. Because every stage has its own optional shuffle, one pass through the network can apply any number of shuffles from none up to `LOG_N`. Any transfer that a single-stage shuffle-exchange network completes in `x` recirculations therefore needs only `ceil(x/LOG_N)` passes here. Every control setting is a permutation of the lanes, and there is no broadcast.

A word set enters with its control vectors on a valid/ready handshake. The stages are purely combinational, and the routed result is captured in one output register. A beat is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. The routed lanes appear on `data_out` with `out_valid` high right after that edge. The result stays on `data_out`, unchanged, until a rising edge where `out_ready` is high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so back-pressure from `out_ready` passes straight through to the input. Control vectors are sampled only on the accepting edge.

Top module: `shuffle_xchg_net`

## Requirements
- R1: Shuffle: when bit k of `shuffle_en` is set, stage k moves the word on lane a to lane ((a<<1) | (a>>(LOG_N-1))) mod N, which is a left rotation of the lane address bits, for every lane at once.
- R2: Exchange: bit k*(N/2)+j of `exch_en` makes stage k swap lanes 2j and 2j+1. Pairs whose bit is clear pass straight through.
- R3: Order: within a stage the optional shuffle acts before the optional exchange. Stage 0 sees `data_in`, and each stage k feeds stage k+1. Lane i occupies bits i*W upward in the flat data buses.
- R4: With all control bits clear, `data_out` equals `data_in`.
- R5: Setting the shuffle bits of k stages and no exchange bits rotates lane addresses left by k. With all LOG_N shuffle bits set, the result is the identity.
- R6: Every setting is a permutation: the output lanes carry exactly the input words, with none lost or duplicated.
- R7: An accepted beat shows its routed result on `data_out` with `out_valid` high directly after the accepting edge. A drained register with no new beat leaves `out_valid` low.
- R8: While `out_valid` is high and `out_ready` is low, `data_out` and `out_valid` hold their values.
- R9: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low.
- R10: Synchronous active-low `rst_n` clears `out_valid`, and `in_ready` is high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Network can accept a beat |
| data_in | input | N*W | Input lanes, lane i at bits i*W +: W |
| shuffle_en | input | LOG_N | Per-stage shuffle enable, bit k for stage k |
| exch_en | input | LOG_N*N/2 | Exchange enables, bit k*(N/2)+j for pair j of stage k |
| out_valid | output | 1 | Routed result present |
| out_ready | input | 1 | Downstream takes the result |
| data_out | output | N*W | Routed output lanes |

## Verification
On every cycle, the bound assertions check the handshake rules: a stalled result is held, `in_ready` drops under a stall, acceptance leads to `out_valid`, and draining without a new beat empties the register. They also check that the XOR of all output lanes equals that of the accepted input lanes, which is a cheap permutation witness. The actual lane mapping cannot be seen cycle by cycle without repeating the routing logic. Shuffle direction, the shuffle-before-exchange order, multi-shuffle rotation and the identity cases are therefore shown only by the bench scenarios. These compare each result against an address-arithmetic model under varied back-pressure.

// File: rtl/sxn_pkg.sv
`timescale 1ns/1ps
package sxn_pkg;

  // Right rotation of an address of 'bits' bits: the lane that feeds
  // lane 'a' when a perfect shuffle (left rotation) is applied.
  function automatic int rotr_idx(input int a, input int bits);
    int mask;
    mask = (1 << bits) - 1;
    return ((a >> 1) | ((a & 1) << (bits - 1))) & mask;
  endfunction

  function automatic int pair_of(input int a);
    return a >> 1;
  endfunction

endpackage

// File: rtl/sxn_stage.sv
`timescale 1ns/1ps
module sxn_stage #(
  parameter int LOG_N = 3,
  parameter int W     = 8
) (
  input  logic                              shuf_i,
  input  logic [((1 << LOG_N) / 2)-1:0]     exch_i,
  input  logic [(1 << LOG_N)*W-1:0]         lanes_i,
  output logic [(1 << LOG_N)*W-1:0]         lanes_o
);
  localparam int N    = 1 << LOG_N;
  localparam int HALF = N / 2;

  logic [N*W-1:0] shuffled;

  // optional stage-wide shuffle
  for (genvar a = 0; a < N; a++) begin : g_shuf
    localparam int SRC = sxn_pkg::rotr_idx(a, LOG_N);
    assign shuffled[a*W +: W] = shuf_i ? lanes_i[SRC*W +: W] : lanes_i[a*W +: W];
  end

  // optional exchange per lane pair, after the shuffle
  for (genvar j = 0; j < HALF; j++) begin : g_exch
    logic [W-1:0] even_w, odd_w;
    assign even_w = shuffled[(2*j)*W +: W];
    assign odd_w  = shuffled[(2*j+1)*W +: W];
    assign lanes_o[(2*j)*W +: W]   = exch_i[j] ? odd_w  : even_w;
    assign lanes_o[(2*j+1)*W +: W] = exch_i[j] ? even_w : odd_w;
  end
endmodule

// File: rtl/sxn_fabric.sv
`timescale 1ns/1ps
module sxn_fabric #(
  parameter int LOG_N = 3,
  parameter int W     = 8
) (
  input  logic [LOG_N-1:0]                      shuffle_en,
  input  logic [LOG_N*((1 << LOG_N)/2)-1:0]     exch_en,
  input  logic [(1 << LOG_N)*W-1:0]             lanes_i,
  output logic [(1 << LOG_N)*W-1:0]             lanes_o
);
  localparam int N    = 1 << LOG_N;
  localparam int HALF = N / 2;
  localparam int BUSW = N * W;

  logic [BUSW-1:0] stage_bus [0:LOG_N];

  assign stage_bus[0] = lanes_i;

  for (genvar k = 0; k < LOG_N; k++) begin : g_stage
    sxn_stage #(.LOG_N(LOG_N), .W(W)) u_stage (
      .shuf_i  (shuffle_en[k]),
      .exch_i  (exch_en[k*HALF +: HALF]),
      .lanes_i (stage_bus[k]),
      .lanes_o (stage_bus[k+1])
    );
  end

  assign lanes_o = stage_bus[LOG_N];
endmodule

// File: rtl/sxn_hold_reg.sv
`timescale 1ns/1ps
module sxn_hold_reg #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/shuffle_xchg_net.sv
`timescale 1ns/1ps
module shuffle_xchg_net #(
  parameter int LOG_N = 3,
  parameter int W     = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  in_valid,
  output logic                                  in_ready,
  input  logic [(1 << LOG_N)*W-1:0]             data_in,
  input  logic [LOG_N-1:0]                      shuffle_en,
  input  logic [LOG_N*((1 << LOG_N)/2)-1:0]     exch_en,
  output logic                                  out_valid,
  input  logic                                  out_ready,
  output logic [(1 << LOG_N)*W-1:0]             data_out
);
  localparam int N    = 1 << LOG_N;
  localparam int BUSW = N * W;

  logic [BUSW-1:0] routed;
  logic            accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  sxn_fabric #(.LOG_N(LOG_N), .W(W)) u_fabric (
    .shuffle_en (shuffle_en),
    .exch_en    (exch_en),
    .lanes_i    (data_in),
    .lanes_o    (routed)
  );

  sxn_hold_reg #(.WIDTH(BUSW)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .d     (routed),
    .q     (data_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         out_valid <= 1'b0;
    else if (accept)    out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end
endmodule

// File: rtl/shuffle_xchg_net_chk.sv
`timescale 1ns/1ps
module shuffle_xchg_net_chk #(
  parameter int LOG_N = 3,
  parameter int W     = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic [(1 << LOG_N)*W-1:0] data_in,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic [(1 << LOG_N)*W-1:0] data_out
);
  localparam int N = 1 << LOG_N;

  function automatic logic [W-1:0] lane_xor(input logic [N*W-1:0] v);
    logic [W-1:0] acc;
    acc = '0;
    for (int i = 0; i < N; i++) acc ^= v[i*W +: W];
    return acc;
  endfunction

  assert_reset_clears_R10: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  assert_stall_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(data_out));

  assert_stall_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_empty_accepts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_accept_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_drain_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  assert_lanes_preserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> lane_xor(data_out) == $past(lane_xor(data_in)));
endmodule

bind shuffle_xchg_net shuffle_xchg_net_chk #(.LOG_N(LOG_N), .W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .data_in   (data_in),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .data_out  (data_out)
);

// File: tb/sim_shuffle_xchg_net.sv
`timescale 1ns/1ps
module sim_shuffle_xchg_net;
  localparam int LN   = 3;
  localparam int W    = 8;
  localparam int N    = 1 << LN;
  localparam int HALF = N / 2;
  localparam int NW   = N * W;
  localparam int EW   = LN * HALF;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          in_valid = 0;
  logic          in_ready;
  logic [NW-1:0] data_in = '0;
  logic [LN-1:0] shuffle_en = '0;
  logic [EW-1:0] exch_en = '0;
  logic          out_valid;
  logic          out_ready = 1;
  logic [NW-1:0] data_out;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit stall_mode = 0;
  bit finished = 0;

  logic [NW-1:0] exp_q [$];
  string         tag_q [$];

  always #2 clk = ~clk;   // 250 MHz

  shuffle_xchg_net #(.LOG_N(LN), .W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .data_in(data_in), .shuffle_en(shuffle_en), .exch_en(exch_en),
    .out_valid(out_valid), .out_ready(out_ready), .data_out(data_out)
  );

  task automatic check(input bit ok, input string req, input logic [NW-1:0] act,
                       input logic [NW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model built from R1..R3 address arithmetic
  function automatic logic [NW-1:0] model(input logic [NW-1:0] d, input logic [LN-1:0] s,
                                          input logic [EW-1:0] e);
    logic [NW-1:0] cur, nxt;
    cur = d;
    for (int k = 0; k < LN; k++) begin
      if (s[k]) begin
        for (int a = 0; a < N; a++) begin
          int dst;
          dst = ((a << 1) | (a >> (LN - 1))) & (N - 1);
          nxt[dst*W +: W] = cur[a*W +: W];
        end
        cur = nxt;
      end
      for (int j = 0; j < HALF; j++) begin
        if (e[k*HALF + j]) begin
          logic [W-1:0] t;
          t = cur[(2*j)*W +: W];
          cur[(2*j)*W +: W]   = cur[(2*j+1)*W +: W];
          cur[(2*j+1)*W +: W] = t;
        end
      end
    end
    return cur;
  endfunction

  function automatic logic [NW-1:0] lanes(input int base, input int step);
    logic [NW-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(base + i * step);
    return v;
  endfunction

  // driver: push expected item, hold beat until accepted
  task automatic send(input logic [NW-1:0] d, input logic [LN-1:0] s,
                      input logic [EW-1:0] e, input logic [NW-1:0] exp, input string tag);
    in_valid   = 1;
    data_in    = d;
    shuffle_en = s;
    exch_en    = e;
    while (!in_ready) @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 0;
    check(out_valid === 1'b1, "R7 out_valid after accept", {{(NW-1){1'b0}}, out_valid}, 1);
  endtask

  // back-pressure generator
  always @(posedge clk) begin
    cyc <= cyc + 1;
    out_ready <= stall_mode ? (cyc % 3 == 0) : 1'b1;
  end

  // monitor: compare on each output handshake, check stall behaviour
  logic [NW-1:0] held;
  bit            was_stall = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (was_stall)
        check(out_valid && data_out == held, "R8 hold under stall", data_out, held);
      if (out_valid && !out_ready)
        check(!in_ready, "R9 in_ready low under stall", {{(NW-1){1'b0}}, in_ready}, 0);
      if (!out_valid || out_ready)
        check(in_ready, "R9 in_ready high", {{(NW-1){1'b0}}, in_ready}, 1);
      was_stall = out_valid && !out_ready;
      held      = data_out;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R7 unexpected output", data_out, '0);
        end else begin
          logic [NW-1:0] e;
          string t;
          bit distinct;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(data_out == e, t, data_out, e);
          distinct = 1;
          for (int i = 0; i < N; i++)
            for (int j = i + 1; j < N; j++)
              if (data_out[i*W +: W] == data_out[j*W +: W]) distinct = 0;
          check(distinct, "R6 lanes distinct", data_out, e);
        end
      end
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [NW-1:0] idx;
    logic [NW-1:0] hand;
    idx = lanes(0, 1);
    repeat (5) @(negedge clk);
    check(out_valid === 1'b0, "R10 out_valid after reset", {{(NW-1){1'b0}}, out_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    check(out_valid === 1'b0 && in_ready === 1'b1, "R10 idle after reset",
          {{(NW-2){1'b0}}, out_valid, in_ready}, 1);

    // R4 identity
    send(idx, '0, '0, idx, "R4 identity");
    send(lanes(7, 29), '0, '0, lanes(7, 29), "R4 identity pattern");

    // R1 single shuffle on one stage, lane a -> rotl(a)
    hand = '0;
    for (int a = 0; a < N; a++) hand[((((a << 1) | (a >> (LN-1))) & (N-1)))*W +: W] = W'(a);
    send(idx, 3'b001, '0, hand, "R1 shuffle stage0");
    send(idx, 3'b100, '0, hand, "R1 shuffle stage2");

    // R2 exchange pairs 0 and 2 on stage 1
    hand = idx;
    hand[0*W +: W] = 8'd1; hand[1*W +: W] = 8'd0;
    hand[4*W +: W] = 8'd5; hand[5*W +: W] = 8'd4;
    send(idx, '0, EW'(4'b0101 << HALF), hand, "R2 exchange pairs");

    // R3 shuffle then exchange in stage 0: lane0 gets 4, lane1 gets 0
    hand = '0;
    for (int a = 0; a < N; a++) hand[((((a << 1) | (a >> (LN-1))) & (N-1)))*W +: W] = W'(a);
    hand[0*W +: W] = 8'd4; hand[1*W +: W] = 8'd0;
    send(idx, 3'b001, EW'(1), hand, "R3 shuffle before exchange");

    // R5 two shuffles rotate by two, all shuffles give identity
    hand = '0;
    for (int a = 0; a < N; a++) hand[((((a << 2) | (a >> (LN-2))) & (N-1)))*W +: W] = W'(a);
    send(idx, 3'b011, '0, hand, "R5 two shuffles");
    send(idx, 3'b111, '0, idx, "R5 full rotation identity");

    // R3 R6 random settings without back-pressure
    for (int r = 0; r < 30; r++) begin
      logic [LN-1:0] s;
      logic [EW-1:0] e;
      logic [NW-1:0] d;
      s = LN'($urandom);
      e = EW'($urandom);
      d = lanes(r * 11, 37);
      send(d, s, e, model(d, s, e), "R3 random routing");
    end

    // R8 R9 random settings under back-pressure
    stall_mode = 1;
    @(negedge clk);
    for (int r = 0; r < 30; r++) begin
      logic [LN-1:0] s;
      logic [EW-1:0] e;
      logic [NW-1:0] d;
      s = LN'($urandom);
      e = EW'($urandom);
      d = lanes(r * 5 + 3, 23);
      send(d, s, e, model(d, s, e), "R8 routing under stall");
    end
    stall_mode = 0;

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R7 all results delivered", NW'(exp_q.size()), 0);
    check(out_valid === 1'b0, "R7 drained", {{(NW-1){1'b0}}, out_valid}, 0);
    finish_run();
  end
endmodule